// File: doc/BRIEF.md
# TDM Short-Sync Slot Receiver

This block receives a time-division multiplexed serial audio stream as a clock slave. It runs on the incoming bit clock and samples the frame-sync and data lines on its rising edge. A frame-sync pulse one bit clock wide marks the start of each frame. After that pulse the block takes a programmable number of back-to-back 16-bit slots, MSB first, and hands each one out as a parallel sample with its slot number and a one-cycle strobe. Every bit clock after the last active slot is padding up to the next sync, and the block drops it.

The typical stream runs at 16 kHz frames with 144 bit clocks each (2.304 MHz). It has six active 16-bit slots (96 bits) and then 48 padding bits, and the slot count goes up to eight. A start-offset input selects whether the first data bit shares the sync clock or arrives one clock later. An optional pairing output joins each even/odd pair of slots into one 32-bit word, so eight narrow channels appear as four wide ones. The block checks the frame length against the nominal value and records any deviation in a sticky flag, which a clear input resets.

Top module: `tdm_slot_rx`

## Requirements
- R1: A single high sample of `fsync` on a rising `bclk` edge is a complete frame marker. The bit position restarts at every such edge, and slot 0 is taken from the bits that follow that one edge, so the first channel is never lost.
- R2: With `late_start`=0 the data bit sampled on the sync edge itself is bit 15 (MSB) of slot 0. With `late_start`=1 that bit is ignored, and the MSB of slot 0 is sampled on the next edge.
- R3: Slots are 16 contiguous bits, MSB first. On the edge that samples a slot's last bit, the registered outputs update. `sample_valid` is high for exactly the following cycle, with `sample_data` holding the slot and `sample_slot` holding its index counted from 0.
- R4: `slot_count` selects how many slots follow the sync. Values 0 to 8 are used as given, and values above 8 act as 8. Value 0 yields no samples.
- R5: Bits after the last active slot and before the next sync produce no `sample_valid`.
- R6: With `pack_en`=1, `pair_valid` rises together with each odd slot's `sample_valid`. `pair_data[31:16]` then holds the preceding even slot, `pair_data[15:0]` holds the odd slot, and `pair_index` = slot/2. A trailing even slot with no partner gives no pair. With `pack_en`=0, `pair_valid` stays low.
- R7: From reset until the first sync, no sample, pair or framing error is produced.
- R8: Once locked, `frame_err` is set after an edge where a sync arrives fewer than 144 edges after the previous one. It is also set after the 144th edge following a sync when no new sync has come. It stays set until cleared.
- R9: `err_clear` high on an edge clears `frame_err` after that edge, unless a new framing error is detected on the same edge, in which case the flag stays set.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; everything samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | One-bit-clock frame marker |
| sdata | input | 1 | Serial data, MSB first |
| late_start | input | 1 | 1: first data bit one clock after sync; 0: on the sync clock |
| pack_en | input | 1 | Enables the 32-bit pairing output |
| err_clear | input | 1 | Clears the framing-error flag |
| slot_count | input | 4 | Number of active slots (0 to 8, larger values act as 8) |
| sample_valid | output | 1 | One-cycle strobe per completed slot |
| sample_data | output | 16 | Completed slot |
| sample_slot | output | 3 | Index of the completed slot |
| pair_valid | output | 1 | One-cycle strobe per completed even/odd pair |
| pair_data | output | 32 | Even slot in the upper half, odd slot in the lower half |
| pair_index | output | 2 | Index of the pair |
| frame_err | output | 1 | Sticky frame-length error |

## Verification
Every result is a register loaded on the rising edge that samples the decisive input bit. A slot's sample and its pair word appear right after the edge carrying the slot's last bit. The framing flag changes right after the offending sync edge, or right after the 144th edge without a sync. The bench drives one bit per clock on the falling edge and inspects all outputs a quarter period after every rising edge. It compares them against a model that places each bit by its frame position and the start offset. This way a strobe that comes one cycle early or late, or one that is missing or extra, is caught on the exact edge where it differs.

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
  parameter int SLOT_BITS  = 16,
  parameter int MAX_SLOTS  = 8,
  parameter int FRAME_BITS = 144,
  localparam int CW = $clog2(MAX_SLOTS + 1),
  localparam int SW = $clog2(MAX_SLOTS),
  localparam int PW = (SW > 1) ? SW - 1 : 1,
  localparam int GW = $clog2(FRAME_BITS) + 1
) (
  input  logic                   bclk,
  input  logic                   rst_n,
  input  logic                   fsync,
  input  logic                   sdata,
  input  logic                   late_start,
  input  logic                   pack_en,
  input  logic                   err_clear,
  input  logic [CW-1:0]          slot_count,
  output logic                   sample_valid,
  output logic [SLOT_BITS-1:0]   sample_data,
  output logic [SW-1:0]          sample_slot,
  output logic                   pair_valid,
  output logic [2*SLOT_BITS-1:0] pair_data,
  output logic [PW-1:0]          pair_index,
  output logic                   frame_err
);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int IW = GW + 1;

  logic [GW-1:0]        gap;
  logic                 locked;
  logic [SLOT_BITS-2:0] shreg;

  // slot width must be a power of two for the in-slot bit field below
  logic [CW-1:0] eff_count;
  logic [IW-1:0] idx, active_bits;
  logic          take, slot_end, pair_end, early_sync, no_sync;
  logic [SW-1:0] cur_slot;

  assign eff_count   = (slot_count > CW'(MAX_SLOTS)) ? CW'(MAX_SLOTS) : slot_count;
  assign active_bits = IW'(int'(eff_count) * SLOT_BITS);
  assign idx         = fsync ? '0 : ({1'b0, gap} + IW'(!late_start));
  assign take        = (locked || fsync) && !(fsync && late_start) && (idx < active_bits);
  assign slot_end    = take && (idx[BW-1:0] == BW'(SLOT_BITS - 1));
  assign cur_slot    = idx[BW +: SW];
  assign pair_end    = slot_end && pack_en && cur_slot[0];
  assign early_sync  = locked && fsync && (gap < GW'(FRAME_BITS - 1));
  assign no_sync     = locked && !fsync && (gap == GW'(FRAME_BITS - 1));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      gap          <= '0;
      locked       <= 1'b0;
      shreg        <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      sample_slot  <= '0;
      pair_valid   <= 1'b0;
      pair_data    <= '0;
      pair_index   <= '0;
      frame_err    <= 1'b0;
    end else begin
      if (fsync)          gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
      if (fsync) locked <= 1'b1;
      if (take) shreg <= {shreg[SLOT_BITS-3:0], sdata};
      sample_valid <= slot_end;
      if (slot_end) begin
        sample_data <= {shreg, sdata};
        sample_slot <= cur_slot;
      end
      pair_valid <= pair_end;
      if (pair_end) begin
        pair_data  <= {sample_data, shreg, sdata};
        pair_index <= PW'(cur_slot >> 1);
      end
      if (early_sync || no_sync) frame_err <= 1'b1;
      else if (err_clear)        frame_err <= 1'b0;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge bclk) disable iff (!rst_n)
    sample_valid |=> !sample_valid) else $error("sample strobe longer than one cycle"); // R3
  AST_SLOT_LIMIT: assert property (@(posedge bclk) disable iff (!rst_n)
    sample_valid |-> (CW'(sample_slot) < $past(eff_count))) else $error("slot beyond count"); // R4
  AST_PAIR_ODD: assert property (@(posedge bclk) disable iff (!rst_n)
    pair_valid |-> (sample_valid && sample_slot[0])) else $error("pair without odd slot"); // R6
  AST_QUIET_UNLOCKED: assert property (@(posedge bclk) disable iff (!rst_n)
    !locked |-> (!sample_valid && !pair_valid && !frame_err)) else $error("output before sync"); // R7
  AST_ERR_STICKY: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_err && !err_clear) |=> frame_err) else $error("error flag dropped"); // R8
endmodule

// File: tb/tdm_slot_rx_tb.sv
module tdm_slot_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 144;

  logic        bclk = 1'b0, rst_n = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic        late_start = 1'b1, pack_en = 1'b0, err_clear = 1'b0;
  logic [3:0]  slot_count = 4'd6;
  logic        sample_valid, pair_valid, frame_err;
  logic [15:0] sample_data;
  logic [2:0]  sample_slot;
  logic [31:0] pair_data;
  logic [1:0]  pair_index;

  int n_checks = 0, n_fail = 0, prev_len = FRAME;
  bit b_locked = 1'b0, exp_err = 1'b0, done = 1'b0;

  tdm_slot_rx u_dut (
    .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
    .late_start(late_start), .pack_en(pack_en), .err_clear(err_clear),
    .slot_count(slot_count), .sample_valid(sample_valid), .sample_data(sample_data),
    .sample_slot(sample_slot), .pair_valid(pair_valid), .pair_data(pair_data),
    .pair_index(pair_index), .frame_err(frame_err)
  );

  always #(CLK_PERIOD/2) bclk = ~bclk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit fs, input bit d, input bit clr);
    @(negedge bclk);
    fsync = fs; sdata = d; err_clear = clr;
    @(posedge bclk);
    #(CLK_PERIOD/4);
  endtask

  task automatic run_frame(input int len, input int cfg, input bit late, input bit pack,
                           input bit sync, input int clr_at);
    logic [15:0] w [8];
    int eff, active, seen, due;
    for (int i = 0; i < 8; i++) w[i] = 16'($urandom);
    eff = (cfg > 8) ? 8 : cfg;
    active = eff * 16;
    seen = 0;
    due = ((late ? len - 1 : len) / 16 < eff) ? (late ? len - 1 : len) / 16 : eff;
    slot_count = 4'(cfg); late_start = late; pack_en = pack;
    for (int e = 0; e < len; e++) begin
      bit fs, d, clr, set, ev, pv, pre;
      int idx, s;
      string tag;
      fs  = sync && (e == 0);
      idx = late ? e - 1 : e;
      d   = (idx >= 0 && idx < active) ? w[idx / 16][15 - (idx % 16)] : 1'($urandom);
      clr = (e == clr_at);
      step(fs, d, clr);
      pre = b_locked;
      set = 1'b0;
      if (fs) begin
        if (b_locked && prev_len < FRAME) set = 1'b1;
        b_locked = 1'b1;
      end else if (b_locked && sync && e == FRAME) set = 1'b1;
      if (set) exp_err = 1'b1;
      else if (clr) exp_err = 1'b0;
      ev = b_locked && idx >= 0 && idx < active && (idx % 16) == 15;
      s  = (idx >= 0) ? idx / 16 : 0;
      pv = ev && pack && (s % 2 == 1);
      if (!pre && !fs)                     tag = "R7";
      else if (idx < 0 || idx >= active)   tag = "R5";
      else if (s == 0)                     tag = "R1";
      else if (!late)                      tag = "R2";
      else                                 tag = "R3";
      chk(tag, "sample_valid", sample_valid, ev);
      if (ev) begin
        seen++;
        chk(tag, "sample_data", sample_data, w[s]);
        chk("R3", "sample_slot", sample_slot, s);
      end
      chk("R6", "pair_valid", pair_valid, pv);
      if (pv) begin
        chk("R6", "pair_data", pair_data, {w[s-1], w[s]});
        chk("R6", "pair_index", pair_index, s / 2);
      end
      chk(clr ? "R9" : "R8", "frame_err", frame_err, exp_err);
    end
    if (sync) begin
      prev_len = len;
      chk("R4", "samples in frame", seen, due);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge bclk);
    #(CLK_PERIOD/4);
    chk("R10", "sample_valid in reset", sample_valid, 0);
    chk("R10", "sample_data in reset", sample_data, 0);
    chk("R10", "pair_valid in reset", pair_valid, 0);
    chk("R10", "pair_data in reset", pair_data, 0);
    chk("R10", "frame_err in reset", frame_err, 0);
    @(negedge bclk) rst_n = 1'b1;

    run_frame(200, 6, 1, 1, 0, -1);           // R7 noise before any sync
    repeat (3) run_frame(FRAME, 6, 1, 0, 1, -1);
    repeat (2) run_frame(FRAME, 6, 0, 0, 1, -1); // R2
    run_frame(FRAME, 8, 1, 1, 1, -1);          // R6
    run_frame(FRAME, 8, 0, 1, 1, -1);
    run_frame(FRAME, 3, 1, 1, 1, -1);          // R6 unpaired tail
    run_frame(FRAME, 1, 0, 1, 1, -1);          // R4
    run_frame(FRAME, 0, 1, 1, 1, -1);          // R4 none
    run_frame(FRAME, 15, 1, 1, 1, -1);         // R4 clamp
    run_frame(100, 6, 1, 0, 1, -1);            // short frame
    run_frame(FRAME, 6, 1, 0, 1, 0);           // R8 set wins over R9 clear
    run_frame(FRAME, 6, 1, 0, 1, 50);          // R9 clear
    run_frame(150, 4, 0, 1, 1, -1);            // R8 missing sync
    run_frame(FRAME, 4, 0, 1, 1, 10);          // R9
    for (int k = 0; k < 40; k++) begin
      int len, cfg, clr_at;
      cfg    = $urandom_range(0, 9);
      len    = ($urandom_range(0, 5) == 0) ? $urandom_range(120, 160) : FRAME;
      clr_at = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 143) : -1;
      run_frame(len, cfg, 1'($urandom), 1'($urandom), 1, clr_at);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule